// File: doc/BRIEF.md
# Digit-Serial BCD Decimal Multiplier

This block multiplies two unsigned N-digit decimal numbers coded in BCD. The multiplicand is presented all at once and captured on a start pulse. The multiplier is then fed one BCD digit at a time, least significant digit first, with a valid flag. The product comes out one BCD digit per cycle, also least significant digit first, with its own valid flag. There are 2N product digits in total.

For each multiplier digit, an array of digit multipliers forms the product of that digit with every multiplicand digit. Each digit product is split into a tens digit and a units digit. Each product column then adds four things in binary: its units digit, the tens digit from the column below, the pending sum digit and the pending carry. A small comparison converts the column value back to decimal. The lowest column yields the outgoing product digit. The remaining sum digits shift down one place, and each column's carry moves into the next column for the following cycle. Because carries only travel one column per cycle, no carry ripples across the word, and a new multiplier digit can be taken every cycle.

After the N-th multiplier digit, the block runs N flush cycles with a zero multiplier digit. These cycles emit the upper half of the product. It then raises done and holds it until the next start.

Top module: `bcd_serial_mult`

## Requirements
- R1: After reset, pdig_valid and done are low, and no product digit is emitted until a start pulse has been seen.
- R2: A start pulse captures the multiplicand (digit i in bits 4i+3..4i), clears all partial state and, from any state, begins a new product. In the cycle after start, pdig_valid and done are low.
- R3: While multiplier digits are still expected, each cycle with mdig_valid high consumes one digit and produces exactly one product digit in the next cycle. A cycle with mdig_valid low produces none, so the operation stalls.
- R4: The 2N product digits emitted after a start equal the decimal product of the multiplicand and the multiplier, least significant digit first.
- R5: Once the N-th multiplier digit is consumed, the N upper product digits follow in the N cycles after it, back to back, with no further input.
- R6: done rises in the cycle that presents the 2N-th product digit and stays high until the next start. While done is high, mdig_valid has no effect and pdig_valid stays low.
- R7: Operands of all nines (the largest column sums) give the correct product. Every column carry stays at or below 2.
- R8: Every emitted product digit is a valid BCD value from 0 to 9.
- R9: A start during an operation in progress discards that operation. The next 2N digits belong only to the new operands.
- R10: When start and mdig_valid are high in the same cycle, start wins and that multiplier digit is not consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a new multiplication and capture the multiplicand |
| mcand | input | 4*N | Multiplicand, N BCD digits, digit 0 in the low nibble |
| mdig_valid | input | 1 | Multiplier digit on mdig is valid this cycle |
| mdig | input | 4 | Multiplier BCD digit, least significant first |
| pdig_valid | output | 1 | Product digit on pdig is valid this cycle |
| pdig | output | 4 | Product BCD digit, least significant first |
| done | output | 1 | All 2N product digits have been emitted |

## Verification
A wrong digit product, column conversion or carry hand-over corrupts the outgoing digit at the weight where it arises. Because every pending value reaches column 0 within at most 2N cycles, such an error always reaches the ports before done rises. A wrong sequencer count shows up at once as a missing or extra valid cycle in the flush stream, or as done rising on the wrong digit. For that reason the bench checks the valid and done pattern cycle by cycle, as well as the whole product value, for every pair of two-digit operands.

// File: rtl/bcdm_pkg.sv
package bcdm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_FLUSH   = 2'd2,
    ST_DONE    = 2'd3
  } bcdm_state_t;

  localparam int unsigned DIG_W   = 4;
  localparam int unsigned CARRY_W = 2;
  localparam int unsigned COL_W   = 5;

endpackage

// File: rtl/bcdm_rst_sync.sv
module bcdm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/bcdm_digit_mul.sv
module bcdm_digit_mul
  import bcdm_pkg::*;
(
  input  logic [DIG_W-1:0] a,
  input  logic [DIG_W-1:0] b,
  output logic [DIG_W-1:0] tens,
  output logic [DIG_W-1:0] units
);
  logic [6:0] prod;
  logic [6:0] tq;
  logic [6:0] rem;

  always_comb begin
    prod  = {3'b000, a} * {3'b000, b};
    tq    = prod / 7'd10;
    rem   = prod - tq * 7'd10;
    tens  = tq[DIG_W-1:0];
    units = rem[DIG_W-1:0];
  end
endmodule

// File: rtl/bcdm_column.sv
module bcdm_column
  import bcdm_pkg::*;
(
  input  logic [DIG_W-1:0]   unit_in,
  input  logic [DIG_W-1:0]   tens_in,
  input  logic [DIG_W-1:0]   sum_in,
  input  logic [CARRY_W-1:0] carry_in,
  output logic [CARRY_W-1:0] carry_out,
  output logic [DIG_W-1:0]   digit_out
);
  logic [COL_W-1:0] bin;

  always_comb begin
    bin = {1'b0, unit_in} + {1'b0, tens_in} + {1'b0, sum_in} + {3'b000, carry_in};
    if (bin >= 5'd20) begin
      carry_out = 2'd2;
      digit_out = 4'(bin - 5'd20);
    end else if (bin >= 5'd10) begin
      carry_out = 2'd1;
      digit_out = 4'(bin - 5'd10);
    end else begin
      carry_out = 2'd0;
      digit_out = bin[DIG_W-1:0];
    end
  end
endmodule

// File: rtl/bcdm_ctrl.sv
module bcdm_ctrl
  import bcdm_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic start,
  input  logic mdig_valid,
  output logic step,
  output logic collecting,
  output logic flushing,
  output logic done
);
  localparam int unsigned CW = $clog2(N) + 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  bcdm_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    step    = 1'b0;
    if (start) begin
      state_d = ST_COLLECT;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_COLLECT: if (mdig_valid) begin
          step = 1'b1;
          if (cnt_q == LAST) begin
            state_d = ST_FLUSH;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_FLUSH: begin
          step = 1'b1;
          if (cnt_q == LAST) begin
            state_d = ST_DONE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign collecting = (state_q == ST_COLLECT);
  assign flushing   = (state_q == ST_FLUSH);
  assign done       = (state_q == ST_DONE);

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    done && !start |=> done);
  assert_no_step_when_done_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    done && mdig_valid |=> !flushing && !collecting || $past(start));
endmodule

// File: rtl/bcd_serial_mult.sv
module bcd_serial_mult
  import bcdm_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [4*N-1:0] mcand,
  input  logic           mdig_valid,
  input  logic [3:0]     mdig,
  output logic           pdig_valid,
  output logic [3:0]     pdig,
  output logic           done
);
  localparam int unsigned NCOL = N + 1;
  localparam int unsigned OCW  = $clog2(2 * N + 1) + 1;

  logic rst_sn;
  logic step, collecting, flushing;

  logic [4*N-1:0]     mcand_q;
  logic [DIG_W-1:0]   sum_q   [NCOL];
  logic [DIG_W-1:0]   sum_d   [NCOL];
  logic [CARRY_W-1:0] carry_q [NCOL];
  logic [CARRY_W-1:0] carry_d [NCOL];
  logic               pval_q, pval_d;
  logic [DIG_W-1:0]   pdig_q, pdig_d;

  logic [DIG_W-1:0]   mul_digit;
  logic [DIG_W-1:0]   dp_tens  [N];
  logic [DIG_W-1:0]   dp_units [N];
  logic [DIG_W-1:0]   col_unit [NCOL];
  logic [DIG_W-1:0]   col_tens [NCOL];
  logic [CARRY_W-1:0] col_carry[NCOL];
  logic [DIG_W-1:0]   col_digit[NCOL];

  bcdm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  bcdm_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_sn(rst_sn), .start(start), .mdig_valid(mdig_valid),
    .step(step), .collecting(collecting), .flushing(flushing), .done(done)
  );

  assign mul_digit = flushing ? '0 : mdig;

  for (genvar i = 0; i < N; i++) begin : g_dp
    bcdm_digit_mul u_dm (
      .a(mcand_q[4*i +: 4]), .b(mul_digit),
      .tens(dp_tens[i]), .units(dp_units[i])
    );
  end

  for (genvar j = 0; j < NCOL; j++) begin : g_col
    if (j < N) begin : g_u
      assign col_unit[j] = dp_units[j];
    end else begin : g_u0
      assign col_unit[j] = '0;
    end
    if (j > 0) begin : g_t
      assign col_tens[j] = dp_tens[j-1];
    end else begin : g_t0
      assign col_tens[j] = '0;
    end
    bcdm_column u_col (
      .unit_in(col_unit[j]), .tens_in(col_tens[j]),
      .sum_in(sum_q[j]), .carry_in(carry_q[j]),
      .carry_out(col_carry[j]), .digit_out(col_digit[j])
    );
  end

  always_comb begin
    for (int j = 0; j < NCOL; j++) begin
      sum_d[j]   = sum_q[j];
      carry_d[j] = carry_q[j];
    end
    pval_d = 1'b0;
    pdig_d = pdig_q;
    if (start) begin
      for (int j = 0; j < NCOL; j++) begin
        sum_d[j]   = '0;
        carry_d[j] = '0;
      end
    end else if (step) begin
      for (int j = 0; j < NCOL; j++) begin
        sum_d[j]   = (j < N) ? col_digit[(j < N) ? j + 1 : j] : '0;
        carry_d[j] = col_carry[j];
      end
      pval_d = 1'b1;
      pdig_d = col_digit[0];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mcand_q <= '0;
      pval_q  <= 1'b0;
      pdig_q  <= '0;
      for (int j = 0; j < NCOL; j++) begin
        sum_q[j]   <= '0;
        carry_q[j] <= '0;
      end
    end else begin
      if (start) mcand_q <= mcand;
      pval_q <= pval_d;
      pdig_q <= pdig_d;
      for (int j = 0; j < NCOL; j++) begin
        sum_q[j]   <= sum_d[j];
        carry_q[j] <= carry_d[j];
      end
    end
  end

  assign pdig_valid = pval_q;
  assign pdig       = pdig_q;

  // output digit counter used only by the checks below
  logic [OCW-1:0] ocnt_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     ocnt_q <= '0;
    else if (start)  ocnt_q <= '0;
    else if (pval_q) ocnt_q <= ocnt_q + 1'b1;
  end

  assert_pdig_bcd_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    pdig_valid |-> pdig <= 4'd9);
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    start |=> !pdig_valid && !done);
  assert_accept_emits_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    collecting && mdig_valid && !start |=> pdig_valid);
  assert_flush_stream_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    flushing && !start |=> pdig_valid);
  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(done) && done |-> !pdig_valid);
  assert_digit_count_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(done) |-> (ocnt_q + OCW'(pdig_valid)) == OCW'(2 * N));

  for (genvar j = 0; j < NCOL; j++) begin : g_chk
    assert_carry_bound_R7: assert property (@(posedge clk) disable iff (!rst_sn)
      carry_q[j] <= 2'd2);
  end
endmodule

// File: tb/sim_bcd_serial_mult.sv
`timescale 1ns/1ps
module sim_bcd_serial_mult;
  localparam int N = 2;
  localparam int MAXV = 100;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [4*N-1:0] mcand;
  logic           mdig_valid;
  logic [3:0]     mdig;
  logic           pdig_valid;
  logic [3:0]     pdig;
  logic           done;

  int errs = 0;
  int checks = 0;
  int got, scale, ndig;

  always #4 clk = ~clk;

  bcd_serial_mult #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mdig_valid(mdig_valid), .mdig(mdig),
    .pdig_valid(pdig_valid), .pdig(pdig), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dig(input int v, input int i);
    int p = 1;
    for (int k = 0; k < i; k++) p = p * 10;
    return (v / p) % 10;
  endfunction

  function automatic logic [4*N-1:0] to_bcd(input int v);
    logic [4*N-1:0] r = '0;
    for (int i = 0; i < N; i++) r[4*i +: 4] = 4'(dig(v, i));
    return r;
  endfunction

  // collector, sampled away from the rising edge
  always @(posedge clk) begin
    #2;
    if (pdig_valid) begin
      chk(pdig <= 4'd9, "R8 digit range", int'(pdig), 9);
      got   = got + int'(pdig) * scale;
      scale = scale * 10;
      ndig++;
    end
  end

  task automatic run(input int a, input int b, input bit gap, input bit overlap);
    @(negedge clk);
    mcand = to_bcd(a);
    start = 1'b1;
    mdig_valid = overlap;
    mdig = overlap ? 4'd7 : 4'd0;
    @(negedge clk);
    start = 1'b0;
    mdig_valid = 1'b0;
    got = 0; scale = 1; ndig = 0;
    chk(!pdig_valid && !done, "R2 cleared after start", int'(pdig_valid), 0);
    for (int i = 0; i < N; i++) begin
      mdig = 4'(dig(b, i));
      mdig_valid = 1'b1;
      @(negedge clk);
      mdig_valid = 1'b0;
      if (gap && i < N - 1) begin
        @(negedge clk);
        chk(!pdig_valid, "R3 stall emits nothing", int'(pdig_valid), 0);
      end
    end
    for (int k = 0; k <= N; k++) begin
      chk(pdig_valid, "R5 back-to-back digit", int'(pdig_valid), 1);
      chk(done == (k == N), "R6 done timing", int'(done), int'(k == N));
      if (k < N) @(negedge clk);
    end
    @(negedge clk);
    chk(!pdig_valid && done, "R6 done held, quiet", int'(pdig_valid), 0);
    chk(got == a * b, "R4 product value", got, a * b);
    chk(ndig == 2 * N, "R4 digit count", ndig, 2 * N);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mcand = '0; mdig_valid = 1'b0; mdig = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!pdig_valid && !done, "R1 reset state", int'(pdig_valid) + int'(done), 0);
    mdig_valid = 1'b1; mdig = 4'd5;
    @(negedge clk);
    mdig_valid = 1'b0;
    @(negedge clk);
    chk(!pdig_valid, "R1 no output before start", int'(pdig_valid), 0);

    // R7 largest column sums
    run(99, 99, 1'b0, 1'b0);
    chk(got == 9801, "R7 all nines", got, 9801);

    // R6 digit ignored while done
    @(negedge clk);
    mdig_valid = 1'b1; mdig = 4'd9;
    @(negedge clk);
    mdig_valid = 1'b0;
    chk(!pdig_valid && done, "R6 input ignored when done", int'(pdig_valid), 0);

    // R9 restart mid operation
    @(negedge clk);
    mcand = to_bcd(88); start = 1'b1;
    @(negedge clk);
    start = 1'b0; mdig = 4'd6; mdig_valid = 1'b1;
    @(negedge clk);
    mdig_valid = 1'b0;
    run(37, 54, 1'b0, 1'b0);
    chk(got == 37 * 54, "R9 restart discards old", got, 37 * 54);

    // R10 start wins over a same-cycle digit
    run(63, 28, 1'b0, 1'b1);
    chk(got == 63 * 28, "R10 start priority", got, 63 * 28);

    // exhaustive sweep of two-digit operands
    for (int a = 0; a < MAXV; a++) begin
      for (int b = 0; b < MAXV; b++) begin
        run(a, b, ((a + b) % 3) == 0, 1'b0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule